// File: doc/BRIEF.md
# Register Transfer and Exchange Unit

This block holds a small register file and carries out one register-to-register operation. It has two 32-bit accumulators, A and B. A and B viewed together, with A as the upper half, form the 64-bit double register D. It also has three unsigned 18-bit index registers, X1 to X3. An operation names a source register and a destination register through 8-bit codes. A 2-bit mode chooses between copy and swap, each with or without two's-complement negation of the moved value. When the accumulator and index widths differ, the unit applies partial-field rules. It reports overflow on negation and can set a condition code whose meaning follows the destination's type. Combinations it cannot perform raise an error flag and change no register.

The surrounding datapath fills the registers through a simple load port; operand fetch happens outside. All register, condition, overflow and error values are registered. Each is visible on the outputs one clock after the edge that takes the command. Every write of an operation commits on that single edge, so a swap always sees the values both registers held before the operation.

Top module: `regx_unit`

## Requirements
- R1: While rst_n is low and after its release, A, B, X1, X2, X3, cond_o, ovf_o and err_o are all zero.
- R2: With load_i high, load_data_i is written into the register named by load_code_i. For A or B the low 32 bits are written, for X1 to X3 the low 18 bits, and for D all 64 bits (bits 63:32 to A). If exec_i is also high in that cycle, the operation is dropped. An unknown load code changes nothing. A load never alters cond_o, ovf_o or err_o.
- R3: pair_i[15:8] is the source code and pair_i[7:0] the destination code. The codes are 0x01 for A, 0x02 for B, 0x03 for D, and 0x81, 0x82, 0x83 for X1, X2, X3. mode_i[1] set means negate and mode_i[0] set means swap.
- R4: Mode 00 copies the source into the destination and leaves the source unchanged.
- R5: Mode 01 swaps the two registers. The source receives the destination's old value and the destination receives the source's old value, both on one edge.
- R6: Modes 10 and 11 behave like 00 and 01, except that the destination receives the two's complement of the source's original value. This holds when source and destination are the same register.
- R7: When an index value goes into A or B, only bits 17:0 are replaced and bits 31:18 are kept. When A or B goes into an index register, only their bits 17:0 are taken.
- R8: After a legal negating operation, ovf_o is 1 exactly when the source held its most negative value: 0x80000000 for A or B, 0x20000 for an index register, bit 63 alone for D. After any other executed operation ovf_o is 0.
- R9: D may appear only with D as the other operand. D with D in mode 00 leaves both halves unchanged. Modes 10 and 11 negate the full 64-bit value.
- R10: Any of the following is illegal: an unknown code, D paired with any other register, or mode 01 with source equal to destination. An illegal operation sets err_o to 1, sets ovf_o to 0, and leaves every register and cond_o unchanged. A legal operation clears err_o.
- R11: After a legal operation with cc_en_i high, cond_o reflects the destination's final value. It is 1 if the destination's top bit (bit 31 for A or B, 17 for an index register, 63 for D) is set, 2 if the value is zero, and 3 otherwise. With cc_en_i low, cond_o keeps its value.
- R12: In a cycle with neither exec_i nor load_i high, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | Perform the operation described by pair_i and mode_i |
| pair_i | input | 16 | Source code (15:8) and destination code (7:0) |
| mode_i | input | 2 | Bit 1 negate, bit 0 swap |
| cc_en_i | input | 1 | Update cond_o from the destination |
| load_i | input | 1 | Write load_data_i into the register named by load_code_i |
| load_code_i | input | 8 | Register code for the load |
| load_data_i | input | 64 | Load value |
| acc_a_o | output | 32 | Accumulator A |
| acc_b_o | output | 32 | Accumulator B |
| idx_o | output | 54 | X3, X2, X1 from high to low, 18 bits each |
| cond_o | output | 2 | Condition code |
| ovf_o | output | 1 | Overflow of the last executed operation |
| err_o | output | 1 | Last executed operation was illegal |

## Verification
The hardest states to reach come from the fact that the unit only moves values it already holds. From reset every register is zero, and negating or swapping zeros never yields a most-negative source, set upper accumulator bits, or a negative 64-bit D. The stimulus therefore uses the load port to plant boundary values such as 0x80000000, 0x20000 and a D with only bit 63 set. It follows each one with the negating operation that must flag overflow, and with index-to-accumulator copies that expose the preserved upper 14 bits. A pseudo-random phase then mixes loads, legal operations and illegal code pairs. This phase drives self-negation and partial-width swaps through register contents that earlier operations have already scrambled.

// File: rtl/regx_pkg.sv
package regx_pkg;
    localparam int ACC_W   = 32;
    localparam int IDX_W   = 18;
    localparam int NUM_IDX = 3;
    localparam int CODE_W  = 8;
    localparam int DBL_W   = 2 * ACC_W;
    localparam int XSEL_W  = (NUM_IDX > 1) ? $clog2(NUM_IDX) : 1;
    localparam int PAIR_W  = 2 * CODE_W;

    localparam logic [CODE_W-1:0] CODE_A = CODE_W'(8'h01);
    localparam logic [CODE_W-1:0] CODE_B = CODE_W'(8'h02);
    localparam logic [CODE_W-1:0] CODE_D = CODE_W'(8'h03);

    localparam logic [1:0] CC_TOP  = 2'd1;
    localparam logic [1:0] CC_ZERO = 2'd2;
    localparam logic [1:0] CC_REST = 2'd3;

    typedef enum logic [1:0] {RK_A, RK_B, RK_D, RK_X} rkind_e;

    typedef logic [DBL_W-1:0] rval_t;

    typedef struct packed {
        logic [ACC_W-1:0]                a;
        logic [ACC_W-1:0]                b;
        logic [NUM_IDX-1:0][IDX_W-1:0]   x;
        logic [1:0]                      cond;
        logic                            ovf;
        logic                            err;
    } rf_state_t;
endpackage

// File: rtl/regx_decode.sv
module regx_decode
    import regx_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic              ok_o,
    output rkind_e            kind_o,
    output logic [XSEL_W-1:0] xsel_o
);
    always_comb begin
        ok_o   = 1'b0;
        kind_o = RK_A;
        xsel_o = '0;
        if (code_i == CODE_A) begin
            ok_o   = 1'b1;
            kind_o = RK_A;
        end else if (code_i == CODE_B) begin
            ok_o   = 1'b1;
            kind_o = RK_B;
        end else if (code_i == CODE_D) begin
            ok_o   = 1'b1;
            kind_o = RK_D;
        end
        for (int i = 0; i < NUM_IDX; i++) begin
            if (code_i == {1'b1, (CODE_W-1)'(i + 1)}) begin
                ok_o   = 1'b1;
                kind_o = RK_X;
                xsel_o = XSEL_W'(i);
            end
        end
    end
endmodule

// File: rtl/regx_negate.sv
module regx_negate
    import regx_pkg::*;
(
    input  rval_t  val_i,
    input  rkind_e kind_i,
    output rval_t  neg_o,
    output logic   ovf_o
);
    rval_t mask;
    rval_t minv;

    always_comb begin
        case (kind_i)
            RK_X: begin
                mask = rval_t'({IDX_W{1'b1}});
                minv = rval_t'(1) << (IDX_W - 1);
            end
            RK_D: begin
                mask = '1;
                minv = rval_t'(1) << (DBL_W - 1);
            end
            default: begin
                mask = rval_t'({ACC_W{1'b1}});
                minv = rval_t'(1) << (ACC_W - 1);
            end
        endcase
        neg_o = (~val_i + rval_t'(1)) & mask;
        ovf_o = (val_i == minv);
    end
endmodule

// File: rtl/regx_unit.sv
module regx_unit
    import regx_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     exec_i,
    input  logic [PAIR_W-1:0]        pair_i,
    input  logic [1:0]               mode_i,
    input  logic                     cc_en_i,
    input  logic                     load_i,
    input  logic [CODE_W-1:0]        load_code_i,
    input  logic [DBL_W-1:0]         load_data_i,
    output logic [ACC_W-1:0]         acc_a_o,
    output logic [ACC_W-1:0]         acc_b_o,
    output logic [NUM_IDX*IDX_W-1:0] idx_o,
    output logic [1:0]               cond_o,
    output logic                     ovf_o,
    output logic                     err_o
);
    localparam int NUM_PORTS = 3;  // source, destination, load

    rf_state_t st_q, st_d;

    logic [NUM_PORTS-1:0][CODE_W-1:0] code_w;
    logic [NUM_PORTS-1:0]             ok_w;
    rkind_e                           kind_w [NUM_PORTS];
    logic [XSEL_W-1:0]                xsel_w [NUM_PORTS];

    assign code_w[0] = pair_i[PAIR_W-1:CODE_W];
    assign code_w[1] = pair_i[CODE_W-1:0];
    assign code_w[2] = load_code_i;

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_dec
        regx_decode u_dec (
            .code_i (code_w[g]),
            .ok_o   (ok_w[g]),
            .kind_o (kind_w[g]),
            .xsel_o (xsel_w[g])
        );
    end

    function automatic rval_t rd(input rf_state_t s, input rkind_e k,
                                 input logic [XSEL_W-1:0] xs);
        case (k)
            RK_A:    return rval_t'(s.a);
            RK_B:    return rval_t'(s.b);
            RK_D:    return {s.a, s.b};
            default: return rval_t'(s.x[xs]);
        endcase
    endfunction

    function automatic rf_state_t wr(input rf_state_t s, input rkind_e kd,
                                     input logic [XSEL_W-1:0] xs,
                                     input rkind_e ksrc, input rval_t v);
        rf_state_t r = s;
        case (kd)
            RK_A: begin
                if (ksrc == RK_X) r.a[IDX_W-1:0] = v[IDX_W-1:0];
                else              r.a = v[ACC_W-1:0];
            end
            RK_B: begin
                if (ksrc == RK_X) r.b[IDX_W-1:0] = v[IDX_W-1:0];
                else              r.b = v[ACC_W-1:0];
            end
            RK_D:    {r.a, r.b} = v;
            default: r.x[xs] = v[IDX_W-1:0];
        endcase
        return r;
    endfunction

    function automatic logic [1:0] cc_of(input rval_t v, input rkind_e k);
        logic top;
        case (k)
            RK_X:    top = v[IDX_W-1];
            RK_D:    top = v[DBL_W-1];
            default: top = v[ACC_W-1];
        endcase
        if (top)            return CC_TOP;
        else if (v == '0)   return CC_ZERO;
        else                return CC_REST;
    endfunction

    rval_t src_val, dst_val, neg_val, moved;
    logic  neg_ovf, d_misuse, self_swap, legal;

    assign src_val = rd(st_q, kind_w[0], xsel_w[0]);
    assign dst_val = rd(st_q, kind_w[1], xsel_w[1]);

    regx_negate u_neg (
        .val_i  (src_val),
        .kind_i (kind_w[0]),
        .neg_o  (neg_val),
        .ovf_o  (neg_ovf)
    );

    assign moved     = mode_i[1] ? neg_val : src_val;
    assign d_misuse  = ((kind_w[0] == RK_D) || (kind_w[1] == RK_D)) && (code_w[0] != code_w[1]);
    assign self_swap = (mode_i == 2'b01) && (code_w[0] == code_w[1]);
    assign legal     = ok_w[0] && ok_w[1] && !d_misuse && !self_swap;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            if (ok_w[2]) st_d = wr(st_d, kind_w[2], xsel_w[2], RK_D, load_data_i);
        end else if (exec_i) begin
            st_d.err = !legal;
            st_d.ovf = 1'b0;
            if (legal) begin
                if (mode_i[0]) st_d = wr(st_d, kind_w[0], xsel_w[0], kind_w[1], dst_val);
                st_d = wr(st_d, kind_w[1], xsel_w[1], kind_w[0], moved);
                st_d.ovf = mode_i[1] & neg_ovf;
                if (cc_en_i) st_d.cond = cc_of(rd(st_d, kind_w[1], xsel_w[1]), kind_w[1]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_a_o = st_q.a;
    assign acc_b_o = st_q.b;
    assign idx_o   = st_q.x;
    assign cond_o  = st_q.cond;
    assign ovf_o   = st_q.ovf;
    assign err_o   = st_q.err;

    // R10
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i && !load_i && !legal |=> err_o && !ovf_o && $stable(acc_a_o)
            && $stable(acc_b_o) && $stable(idx_o) && $stable(cond_o));

    // R12
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i && !load_i |=> $stable(acc_a_o) && $stable(acc_b_o)
            && $stable(idx_o) && $stable(cond_o) && $stable(ovf_o) && $stable(err_o));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i && !load_i && !mode_i[1] |=> !ovf_o);

    // R11
    cond_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i && !load_i && !cc_en_i |=> $stable(cond_o));

    // R2
    load_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> $stable(cond_o) && $stable(ovf_o) && $stable(err_o));

    // R4
    copy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i && !load_i && legal && (mode_i == 2'b00) && (kind_w[0] == RK_A)
            && (kind_w[1] != RK_A) |=> $stable(acc_a_o));
endmodule

// File: tb/regx_unit_tb.sv
module regx_unit_tb;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        exec_i;
    logic [15:0] pair_i;
    logic [1:0]  mode_i;
    logic        cc_en_i;
    logic        load_i;
    logic [7:0]  load_code_i;
    logic [63:0] load_data_i;
    logic [31:0] acc_a_o, acc_b_o;
    logic [53:0] idx_o;
    logic [1:0]  cond_o;
    logic        ovf_o, err_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    regx_unit u_dut (
        .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .pair_i(pair_i),
        .mode_i(mode_i), .cc_en_i(cc_en_i), .load_i(load_i),
        .load_code_i(load_code_i), .load_data_i(load_data_i),
        .acc_a_o(acc_a_o), .acc_b_o(acc_b_o), .idx_o(idx_o),
        .cond_o(cond_o), .ovf_o(ovf_o), .err_o(err_o)
    );

    // behavioural reference state
    logic [31:0] ma, mb;
    logic [17:0] mx [1:3];
    logic [1:0]  mc;
    logic        mo, me;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    function automatic int kind_of(input logic [7:0] c);
        if (c == 8'h01) return 1;
        if (c == 8'h02) return 2;
        if (c == 8'h03) return 3;
        if (c == 8'h81 || c == 8'h82 || c == 8'h83) return 4;
        return 0;
    endfunction

    function automatic int width_of(input int k);
        if (k == 3) return 64;
        if (k == 4) return 18;
        return 32;
    endfunction

    function automatic logic [63:0] get(input logic [7:0] c);
        case (kind_of(c))
            1: return {32'h0, ma};
            2: return {32'h0, mb};
            3: return {ma, mb};
            4: return {46'h0, mx[c[1:0]]};
            default: return 64'h0;
        endcase
    endfunction

    task automatic put(input logic [7:0] c, input bit from_idx, input logic [63:0] v);
        case (kind_of(c))
            1: if (from_idx) ma[17:0] = v[17:0]; else ma = v[31:0];
            2: if (from_idx) mb[17:0] = v[17:0]; else mb = v[31:0];
            3: begin ma = v[63:32]; mb = v[31:0]; end
            4: mx[c[1:0]] = v[17:0];
            default: ;
        endcase
    endtask

    task automatic model_exec(input logic [7:0] c1, input logic [7:0] c2,
                              input logic [1:0] m, input bit cc);
        int k1 = kind_of(c1);
        int k2 = kind_of(c2);
        bit ok = (k1 != 0) && (k2 != 0) && !((k1 == 3 || k2 == 3) && c1 != c2)
                 && !(m == 2'b01 && c1 == c2);
        if (!ok) begin
            me = 1'b1;
            mo = 1'b0;
        end else begin
            logic [63:0] v1 = get(c1);
            logic [63:0] v2 = get(c2);
            int w = width_of(k1);
            logic [63:0] mask = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
            logic [63:0] mv = m[1] ? ((~v1 + 64'd1) & mask) : v1;
            if (m[0]) put(c1, k2 == 4, v2);
            put(c2, k1 == 4, mv);
            me = 1'b0;
            mo = m[1] && (v1 == (64'd1 << (w - 1)));
            if (cc) begin
                logic [63:0] r = get(c2);
                int w2 = width_of(k2);
                if (r[w2-1])         mc = 2'd1;
                else if (r == 64'h0) mc = 2'd2;
                else                 mc = 2'd3;
            end
        end
    endtask

    task automatic compare(input string tag);
        logic [53:0] ex = {mx[3], mx[2], mx[1]};
        vectors++;
        if (acc_a_o !== ma || acc_b_o !== mb || idx_o !== ex || cond_o !== mc
            || ovf_o !== mo || err_o !== me) begin
            misses++;
            $display("FAIL %s: got A=%h B=%h X=%h cc=%0d ov=%b er=%b, expected A=%h B=%h X=%h cc=%0d ov=%b er=%b",
                     tag, acc_a_o, acc_b_o, idx_o, cond_o, ovf_o, err_o,
                     ma, mb, ex, mc, mo, me);
        end
    endtask

    // drive at a falling edge, compare at the next falling edge
    task automatic step(input string tag, input bit ld, input logic [7:0] lc,
                        input logic [63:0] ldat, input bit ex, input logic [7:0] c1,
                        input logic [7:0] c2, input logic [1:0] m, input bit cc);
        load_i = ld; load_code_i = lc; load_data_i = ldat;
        exec_i = ex; pair_i = {c1, c2}; mode_i = m; cc_en_i = cc;
        if (ld) begin
            if (kind_of(lc) != 0) put(lc, 1'b0, ldat);
        end else if (ex) begin
            model_exec(c1, c2, m, cc);
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_ld(input string tag, input logic [7:0] c, input logic [63:0] d);
        step(tag, 1'b1, c, d, 1'b0, 8'h00, 8'h00, 2'b00, 1'b0);
    endtask

    task automatic do_ex(input string tag, input logic [7:0] c1, input logic [7:0] c2,
                         input logic [1:0] m, input bit cc);
        step(tag, 1'b0, 8'h00, 64'h0, 1'b1, c1, c2, m, cc);
    endtask

    task automatic do_idle(input string tag);
        step(tag, 1'b0, 8'h00, 64'h0, 1'b0, 8'h01, 8'h02, 2'b00, 1'b1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        logic [7:0] codes [0:8];
        logic [15:0] lfsr;
        codes[0] = 8'h01; codes[1] = 8'h02; codes[2] = 8'h03;
        codes[3] = 8'h81; codes[4] = 8'h82; codes[5] = 8'h83;
        codes[6] = 8'h04; codes[7] = 8'h80; codes[8] = 8'h01;

        ma = '0; mb = '0; mx[1] = '0; mx[2] = '0; mx[3] = '0;
        mc = '0; mo = 1'b0; me = 1'b0;
        rst_n = 1'b0; exec_i = 1'b0; pair_i = '0; mode_i = '0; cc_en_i = 1'b0;
        load_i = 1'b0; load_code_i = '0; load_data_i = '0;
        repeat (3) @(negedge clk);
        compare("R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after release");

        do_ld("R2 load A", 8'h01, 64'hAAAA_BBBB_1234_5678);
        do_ld("R2 load B", 8'h02, 64'h0000_0000_FFFF_0001);
        do_ld("R2 load X1", 8'h81, 64'h0000_0000_0002_ABCD);
        do_ld("R2 load X2", 8'h82, 64'h0000_0000_0003_5555);
        do_ld("R2 load unknown code", 8'h05, 64'hFFFF_FFFF_FFFF_FFFF);

        do_ex("R3 R4 copy A to B", 8'h01, 8'h02, 2'b00, 1'b1);
        do_ex("R7 copy X1 to A keeps upper", 8'h81, 8'h01, 2'b00, 1'b1);
        do_ex("R7 copy A to X3 low bits", 8'h01, 8'h83, 2'b00, 1'b1);
        do_ex("R5 R7 swap A with X2", 8'h01, 8'h82, 2'b01, 1'b1);
        do_ex("R6 copy negate B to A", 8'h02, 8'h01, 2'b10, 1'b1);
        do_ex("R6 swap negate X1 with B", 8'h81, 8'h02, 2'b11, 1'b1);
        do_ex("R6 self negate A", 8'h01, 8'h01, 2'b11, 1'b1);

        do_ld("R2 load A min", 8'h01, 64'h0000_0000_8000_0000);
        do_ex("R8 negate A min to B", 8'h01, 8'h02, 2'b10, 1'b1);
        do_ex("R8 copy without negate", 8'h01, 8'h81, 2'b00, 1'b1);
        do_ld("R2 load X2 min", 8'h82, 64'h0000_0000_0002_0000);
        do_ex("R8 negate X2 min", 8'h82, 8'h83, 2'b10, 1'b1);
        do_ex("R8 negate nonmin", 8'h81, 8'h83, 2'b10, 1'b1);

        do_ld("R2 load D min", 8'h03, 64'h8000_0000_0000_0000);
        do_ex("R9 R8 negate D min", 8'h03, 8'h03, 2'b10, 1'b1);
        do_ld("R2 load D", 8'h03, 64'h0000_0001_0000_0000);
        do_ex("R9 swap negate D self", 8'h03, 8'h03, 2'b11, 1'b1);
        do_ex("R9 D copy to itself", 8'h03, 8'h03, 2'b00, 1'b1);

        do_ex("R10 R9 D with A", 8'h01, 8'h03, 2'b00, 1'b1);
        do_ex("R10 R9 D to B negate", 8'h03, 8'h02, 2'b10, 1'b1);
        do_ex("R10 unknown source", 8'h04, 8'h01, 2'b00, 1'b1);
        do_ex("R10 unknown index dest", 8'h01, 8'h84, 2'b00, 1'b1);
        do_ex("R10 self swap no negate", 8'h81, 8'h81, 2'b01, 1'b1);
        do_ex("R10 code 0x80", 8'h80, 8'h02, 2'b10, 1'b1);

        do_ld("R2 load X3 zero", 8'h83, 64'h0);
        do_ex("R11 zero index dest", 8'h83, 8'h83, 2'b10, 1'b1);
        do_ld("R2 load X1 top", 8'h81, 64'h0000_0000_0002_0001);
        do_ex("R11 index top bit", 8'h81, 8'h82, 2'b00, 1'b1);
        do_ex("R11 cc disabled holds", 8'h03, 8'h03, 2'b10, 1'b0);

        do_idle("R12 idle 1");
        do_idle("R12 idle 2");
        step("R2 load wins over exec", 1'b1, 8'h02, 64'h0000_0000_0000_7777,
             1'b1, 8'h01, 8'h02, 2'b10, 1'b1);

        lfsr = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            logic [7:0] c1, c2;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            c1 = codes[lfsr[3:0] % 9];
            c2 = codes[lfsr[7:4] % 9];
            if (lfsr[15:13] == 3'b000)
                do_ld("R2 random load", c1, {lfsr, ~lfsr, lfsr ^ 16'h8000, lfsr});
            else if (lfsr[15:13] == 3'b001)
                do_idle("R12 random idle");
            else
                do_ex("R6 R7 R11 random op", c1, c2, lfsr[9:8], lfsr[10]);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule